// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

A reset can strike in the middle of an I2C transfer. When that happens, a target device may be left holding SDA low while it waits for clock edges that never arrive, and the bus stays blocked. This block clears that condition. As soon as reset is released, it takes the SCL pad away from the I2C controller through a pin-multiplexer select. It then clocks the line a fixed number of times, which lets the target shift out the rest of its byte and release SDA. After the last pulse it hands the pad back to the controller.

SCL is driven open-drain. The block can only pull the line low, and for a high phase it releases the line. It then watches the sampled SCL to see that the line actually rises. A target that stretches the clock lengthens the high phase. A line that stays low too long aborts the run with an error flag. After the first automatic run, a start request re-runs the sequence whenever the block is idle.

Top module: `i2c_bus_unstick`

## Requirements
- R1: While reset is held and in the cycle after it is released, the block is already recovering: `scl_drive_low`=1 (pad pulled low), `mux_sel`=1 (pad owned by the block) and `busy`=1, with `done`=0 and `error`=0.
- R2: `mux_sel` is 1 only while a recovery run is active. It returns to 0 (I2C function) when a run completes or aborts. `scl_drive_low` is never 1 while `mux_sel` is 0.
- R3: A successful run produces exactly PULSES (default 20) SCL pulses. Each pulse is a driven-low phase followed by a released phase, and the first phase of a run is low.
- R4: Every low phase lasts exactly PHASE_CYCLES clock cycles.
- R5: Every high phase lasts PHASE_CYCLES cycles during which the sampled SCL is high. Cycles in which the released line is still read low add to the phase, so a stretch of S cycles makes the released phase PHASE_CYCLES+S cycles long.
- R6: If the sampled SCL reads low in STUCK_CYCLES cycles of a single high phase, the run aborts in that cycle. At the abort, `error` rises and stays 1, `busy` and `mux_sel` go to 0, SCL is released and `done` does not pulse. A phase with STUCK_CYCLES-1 such cycles completes without error.
- R7: On successful completion, `done` is 1 for exactly one cycle, in the same cycle that `busy` falls.
- R8: When the block is idle, after a completed or an aborted run, a `start_req` sampled high starts a new run in the next cycle and clears `error`.
- R9: `start_req` while `busy` is 1 is ignored: the run neither restarts nor lengthens, and no extra pulses follow it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; starts a recovery run on release |
| start_req | input | 1 | Request a new recovery run while idle |
| scl_in | input | 1 | Sampled level of the SCL pad |
| scl_drive_low | output | 1 | 1 pulls the SCL pad low, 0 releases it |
| mux_sel | output | 1 | 1 routes the pad to this block, 0 to the I2C controller |
| busy | output | 1 | A recovery run is in progress |
| done | output | 1 | One-cycle pulse at successful completion |
| error | output | 1 | Sticky flag: SCL stayed low while released |

## Verification
The sequence is driven with four SCL patterns. The first is a line that follows the block's drive at once, which checks the plain low and high widths and the pulse count. The second is a line held low for a few cycles on one mid-run pulse, which separates counting cycles from counting observed-high cycles. The third holds the line one cycle short of the timeout on the last pulse, which separates the boundary from an abort. The fourth is a line held low for good, which must abort with the pad handed back. Start requests are issued both while a run is active and from the idle and error states, so that an ignored request can be told apart from a restart by the number of pulses seen.

// File: rtl/unstick_pkg.sv
package unstick_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_FAIL
    } ust_state_e;

    typedef struct packed {
        ust_state_e state;
        logic       done;
        logic       err;
    } ust_regs_t;

endpackage

// File: rtl/unstick_count.sv
module unstick_count #(
    parameter int LIMIT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_last
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (inc)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign at_last = (cnt_q == LAST);

    // R3/R4: a counter is never advanced past its last value
    a_r3_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        at_last && !clr |-> !inc);

endmodule

// File: rtl/unstick_fsm.sv
module unstick_fsm
    import unstick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic scl_in,
    input  logic phase_last,
    input  logic stuck_last,
    input  logic pulse_last,
    output logic phase_clr,
    output logic phase_inc,
    output logic stuck_clr,
    output logic stuck_inc,
    output logic pulse_clr,
    output logic pulse_inc,
    output logic scl_drive_low,
    output logic mux_sel,
    output logic busy,
    output logic done,
    output logic error
);
    ust_regs_t r_d, r_q;

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        phase_clr = 1'b0;
        phase_inc = 1'b0;
        stuck_clr = 1'b0;
        stuck_inc = 1'b0;
        pulse_clr = 1'b0;
        pulse_inc = 1'b0;
        unique case (r_q.state)
            ST_IDLE, ST_FAIL: begin
                if (start_req) begin
                    r_d.state = ST_LOW;
                    r_d.err   = 1'b0;
                    phase_clr = 1'b1;
                    stuck_clr = 1'b1;
                    pulse_clr = 1'b1;
                end
            end
            ST_LOW: begin
                if (phase_last) begin
                    r_d.state = ST_HIGH;
                    phase_clr = 1'b1;
                    stuck_clr = 1'b1;
                end else begin
                    phase_inc = 1'b1;
                end
            end
            ST_HIGH: begin
                if (!scl_in) begin
                    if (stuck_last) begin
                        r_d.state = ST_FAIL;
                        r_d.err   = 1'b1;
                    end else begin
                        stuck_inc = 1'b1;
                    end
                end else if (phase_last) begin
                    phase_clr = 1'b1;
                    if (pulse_last) begin
                        r_d.state = ST_IDLE;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = ST_LOW;
                        pulse_inc = 1'b1;
                    end
                end else begin
                    phase_inc = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_LOW;
            r_q.done  <= 1'b0;
            r_q.err   <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign scl_drive_low = (r_q.state == ST_LOW);
    assign mux_sel       = (r_q.state == ST_LOW) || (r_q.state == ST_HIGH);
    assign busy          = mux_sel;
    assign done          = r_q.done;
    assign error         = r_q.err;

    // R7: completion pulse lasts one cycle
    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: a run only ends by completing or aborting
    a_r7_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || error));

    // R6: an abort follows a cycle with the released line read low
    a_r6_fail_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> $past(!scl_in));

    // R2: pad is never pulled low unless owned
    a_r2_drive_owned: assert property (@(posedge clk) disable iff (!rst_n)
        scl_drive_low |-> mux_sel);

endmodule

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
    parameter int PULSES       = 20,
    parameter int PHASE_CYCLES = 50000,
    parameter int STUCK_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_req,
    input  logic scl_in,
    output logic scl_drive_low,
    output logic mux_sel,
    output logic busy,
    output logic done,
    output logic error
);
    logic phase_clr, phase_inc, phase_last;
    logic stuck_clr, stuck_inc, stuck_last;
    logic pulse_clr, pulse_inc, pulse_last;

    unstick_count #(.LIMIT(PHASE_CYCLES)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(phase_clr), .inc(phase_inc), .at_last(phase_last)
    );

    unstick_count #(.LIMIT(STUCK_CYCLES)) u_stuck (
        .clk(clk), .rst_n(rst_n), .clr(stuck_clr), .inc(stuck_inc), .at_last(stuck_last)
    );

    unstick_count #(.LIMIT(PULSES)) u_pulse (
        .clk(clk), .rst_n(rst_n), .clr(pulse_clr), .inc(pulse_inc), .at_last(pulse_last)
    );

    unstick_fsm u_fsm (
        .clk(clk),
        .rst_n(rst_n),
        .start_req(start_req),
        .scl_in(scl_in),
        .phase_last(phase_last),
        .stuck_last(stuck_last),
        .pulse_last(pulse_last),
        .phase_clr(phase_clr),
        .phase_inc(phase_inc),
        .stuck_clr(stuck_clr),
        .stuck_inc(stuck_inc),
        .pulse_clr(pulse_clr),
        .pulse_inc(pulse_inc),
        .scl_drive_low(scl_drive_low),
        .mux_sel(mux_sel),
        .busy(busy),
        .done(done),
        .error(error)
    );

endmodule

// File: tb/sim_i2c_bus_unstick.sv
module sim_i2c_bus_unstick;
    localparam int CLK_PERIOD = 10;
    localparam int P = 4;
    localparam int T = 16;
    localparam int N = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_req = 1'b0;
    logic scl_drive_low, mux_sel, busy, done, error;
    logic scl_in;

    int hold_cnt = 0;
    int stretch_idx = -1;
    int stretch_len = 0;
    int rel_idx = 0;
    int lo_run = 0;
    int hi_run = 0;
    logic prev_drive = 1'b0;
    int done_seen = 0;
    int checks = 0;
    int fails = 0;
    int exp_q[$];

    assign scl_in = !(scl_drive_low || (hold_cnt > 0));

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_bus_unstick #(.PULSES(N), .PHASE_CYCLES(P), .STUCK_CYCLES(T)) u0 (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .mux_sel(mux_sel), .busy(busy),
        .done(done), .error(error)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_pulse();
        int e;
        if (exp_q.size() == 0) begin
            check(1'b0, "R3/R9 unexpected extra pulse", 1, 0);
        end else begin
            e = exp_q.pop_front();
            check(lo_run == P, "R4 low phase width", lo_run, P);
            check(hi_run == e, "R5 high phase width", hi_run, e);
        end
        lo_run = 0;
        hi_run = 0;
    endtask

    // driver: push expected high widths for the pulses of one run
    task automatic expect_run(input int sidx, input int slen, input int count);
        stretch_idx = sidx;
        stretch_len = slen;
        for (int i = 1; i <= count; i++)
            exp_q.push_back((i == sidx) ? P + slen : P);
    endtask

    task automatic pulse_start();
        @(posedge clk); #1 start_req = 1'b1;
        @(posedge clk); #1 start_req = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (busy && n < 5000);
        @(negedge clk); #1;
    endtask

    // monitor and line model
    always @(negedge clk) begin
        if (!rst_n) begin
            lo_run = 0; hi_run = 0; prev_drive = 1'b0; rel_idx = 0;
        end else begin
            if (hold_cnt > 0) hold_cnt--;
            if (done) done_seen++;
            if (scl_drive_low) begin
                if (hi_run > 0) finish_pulse();
                lo_run++;
            end else if (busy) begin
                if (prev_drive) begin
                    rel_idx++;
                    if (rel_idx == stretch_idx) hold_cnt = stretch_len;
                end
                hi_run++;
            end else begin
                if (done) finish_pulse();
                lo_run = 0; hi_run = 0; rel_idx = 0;
            end
            prev_drive = scl_drive_low;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        summary();
    end

    initial begin
        int d0;
        expect_run(-1, 0, N);
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check(scl_drive_low == 1'b1, "R1 drive low in reset", int'(scl_drive_low), 1);
        check(mux_sel == 1'b1, "R1 mux owned in reset", int'(mux_sel), 1);
        check(busy == 1'b1 && !done && !error, "R1 busy without done/error", int'(busy), 1);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk); #1;
        check(scl_drive_low && mux_sel && busy, "R1 recovery after release", int'(scl_drive_low), 1);

        // run 1: automatic, line follows drive
        wait_idle();
        check(exp_q.size() == 0, "R3 all pulses seen", exp_q.size(), 0);
        check(done_seen == 1, "R7 one done pulse", done_seen, 1);
        check(done == 1'b0, "R7 done single cycle", int'(done), 0);
        check(mux_sel == 1'b0 && !scl_drive_low, "R2 pad handed back", int'(mux_sel), 0);
        check(error == 1'b0, "R6 no error on clean run", int'(error), 0);

        // run 2: restart from idle, stretch on pulse 3, start ignored mid-run
        d0 = done_seen;
        expect_run(3, 5, N);
        pulse_start();
        check(busy == 1'b1 && mux_sel, "R8 start from idle", int'(busy), 1);
        repeat (30) @(posedge clk);
        pulse_start();
        wait_idle();
        check(exp_q.size() == 0, "R9 no restart from busy start", exp_q.size(), 0);
        check(done_seen == d0 + 1, "R9 single done", done_seen - d0, 1);
        repeat (3 * P) @(negedge clk);
        #1;
        check(busy == 1'b0 && !scl_drive_low, "R9 nothing after run", int'(busy), 0);

        // run 3: stretch of T-1 on the last pulse
        d0 = done_seen;
        expect_run(N, T - 1, N);
        pulse_start();
        wait_idle();
        check(error == 1'b0, "R6 boundary no error", int'(error), 0);
        check(done_seen == d0 + 1, "R6 boundary completes", done_seen - d0, 1);
        check(exp_q.size() == 0, "R5 boundary widths", exp_q.size(), 0);

        // run 4: line stuck low from pulse 7
        d0 = done_seen;
        expect_run(7, 1000000, 6);
        pulse_start();
        wait_idle();
        check(error == 1'b1, "R6 stuck line aborts", int'(error), 1);
        check(mux_sel == 1'b0 && !scl_drive_low, "R6 pad handed back on abort", int'(mux_sel), 0);
        check(done_seen == d0, "R6 no done on abort", done_seen - d0, 0);
        check(exp_q.size() == 0, "R6 pulses before abort", exp_q.size(), 0);
        hold_cnt = 0;
        stretch_idx = -1;
        repeat (5) @(negedge clk);
        #1;
        check(error == 1'b1 && !busy, "R6 error sticky", int'(error), 1);

        // run 5: start after abort
        d0 = done_seen;
        expect_run(-1, 0, N);
        pulse_start();
        check(error == 1'b0 && busy, "R8 start clears error", int'(error), 0);
        wait_idle();
        check(exp_q.size() == 0 && done_seen == d0 + 1, "R8 run after abort", exp_q.size(), 0);
        check(mux_sel == 1'b0, "R2 pad returned after rerun", int'(mux_sel), 0);

        summary();
    end

endmodule